// File: doc/BRIEF.md
# Single-Wire Serial Register Port

This block is the register-side end of a one-wire management link. A controller and this port share a single data line that both sides sample on the rising edge of the common clock. The line rests low. A transfer opens with a 1 (start), then a direction bit, then an 8-bit register address. For a write, 8 data bits and a closing stop bit follow on the same wire with the controller still driving. For a read, the controller lets go of the wire, and this port then drives the 8 data bits back.

The port holds a small array of 8-bit registers. One of them, at address 0x06, is the power-mode field, and its contents are also presented on a dedicated output so that the surrounding logic can act on the mode. Writing 0x00 there requests the READY mode. The tri-state driver sits outside the block, and the block supplies a driven value and an output enable for it.

Top module: `srp_serial_port`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sd_oe` is 0 and `pm_mode` equals the reset code 0x02.
- R2: While the line stays low in the idle state, the port never drives it. A transfer begins only when a 1 is sampled in the idle state.
- R3: The bit after the start bit selects the direction (1 = read, 0 = write). Address and data bits travel most significant bit first.
- R4: A write sends 8 address bits, 8 data bits and a stop bit of 0. The value is stored when the stop bit is sampled, and a later read of that address returns it.
- R5: If the bit in the stop position is 1, the write is discarded and the register keeps its old value.
- R6: For a read, the line is left undriven for exactly one cycle after the last address bit is sampled. The port then drives 8 data bits, one per cycle, MSB first.
- R7: After the eighth read bit, the port releases the line for one undriven cycle and then accepts a new start bit on the next edge.
- R8: The port never drives the line at any point during a write transfer.
- R9: Addresses at or above the register count (16) read as 0x00. Writes to them change nothing, and no address aliases onto an implemented register.
- R10: Register 0x06 is the power-mode field and is shown on `pm_mode`. A write of 0x00 to it (READY) appears on `pm_mode` in the cycle after the stop bit is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Link clock; every bit is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sd_in | input | 1 | Resolved value of the shared data line |
| sd_out | output | 1 | Value the port drives onto the line during read data |
| sd_oe | output | 1 | Output enable for the line driver; 1 while the port owns the line |
| pm_mode | output | 8 | Current contents of the power-mode register (address 0x06) |

## Verification
The hardest cases to reach are the ones where the controller breaks the expected framing or addressing. Examples are a stop position carrying 1, and an out-of-range address such as 0x16 whose low bits match the power-mode register. The driver task builds these frames bit by bit. It then reads the targets back through the same wire and watches `pm_mode`, which shows that nothing changed. Two reads are also issued back to back, with the second start bit placed on the first edge after the trailing turnaround, so that the release timing is tested at its tightest point.

// File: rtl/srp_pkg.sv
`timescale 1ns/1ps
package srp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR,
    ST_ADDR,
    ST_WDATA,
    ST_STOP,
    ST_TA1,
    ST_RDATA,
    ST_TA2
  } srp_state_e;
endpackage

// File: rtl/srp_regfile.sv
`timescale 1ns/1ps
module srp_regfile #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int PM_ADDR  = 6,
  parameter logic [7:0] PM_RESET = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] pm_q
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] PM_A  = ADDR_W'(PM_ADDR);

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic [DATA_W-1:0] mem_rd;
  logic              rd_hit_q, rd_pm_q;
  logic              wr_hit, rd_hit;

  assign wr_hit = wr_en && (wr_addr < LIMIT);
  assign rd_hit = rd_addr < LIMIT;

  // plain array: no reset, one write and one registered read port
  always_ff @(posedge clk) begin
    if (wr_hit && wr_addr != PM_A)
      mem[wr_addr[IDX_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en)
      mem_rd <= mem[rd_addr[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_q     <= DATA_W'(PM_RESET);
      rd_hit_q <= 1'b0;
      rd_pm_q  <= 1'b0;
    end else begin
      if (wr_en && wr_addr == PM_A)
        pm_q <= wr_data;
      if (rd_en) begin
        rd_hit_q <= rd_hit;
        rd_pm_q  <= (rd_addr == PM_A);
      end
    end
  end

  assign rd_data = !rd_hit_q ? '0 : (rd_pm_q ? pm_q : mem_rd);

  // R9: a read of an address outside the array returns zero
  a_r9_unimpl_zero: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && !(rd_addr < LIMIT)) |-> rd_data == '0);

  // R10: the power-mode field takes the written value
  a_r10_pm_update: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && wr_addr == PM_A && !rst) |-> pm_q == $past(wr_data));
endmodule

// File: rtl/srp_frame_fsm.sv
`timescale 1ns/1ps
module srp_frame_fsm
  import srp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              drv_oe,
  output logic              drv_bit
);
  localparam int MAXW  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CNT_W = $clog2(MAXW);

  srp_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              rw_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              oe_q, out_q;
  logic [ADDR_W-1:0] full_addr;
  logic              last_addr;

  assign full_addr = {addr_q[ADDR_W-2:0], line_in};
  assign last_addr = (state == ST_ADDR) && (cnt == '0);
  assign rd_en     = last_addr && rw_q;
  assign rd_addr   = full_addr;
  assign wr_en     = (state == ST_STOP) && !line_in;
  assign wr_addr   = addr_q;
  assign wr_data   = data_q;
  assign drv_oe    = oe_q;
  assign drv_bit   = out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      rw_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      oe_q   <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE:  if (line_in) state <= ST_DIR;
        ST_DIR: begin
          rw_q  <= line_in;
          cnt   <= CNT_W'(ADDR_W - 1);
          state <= ST_ADDR;
        end
        ST_ADDR: begin
          addr_q <= full_addr;
          if (cnt == '0) begin
            if (rw_q) state <= ST_TA1;
            else begin
              cnt   <= CNT_W'(DATA_W - 1);
              state <= ST_WDATA;
            end
          end else cnt <= cnt - 1'b1;
        end
        ST_WDATA: begin
          data_q <= {data_q[DATA_W-2:0], line_in};
          if (cnt == '0) state <= ST_STOP;
          else cnt <= cnt - 1'b1;
        end
        ST_STOP: state <= ST_IDLE;
        ST_TA1: begin
          out_q  <= rd_data[DATA_W-1];
          data_q <= {rd_data[DATA_W-2:0], 1'b0};
          oe_q   <= 1'b1;
          cnt    <= CNT_W'(DATA_W - 1);
          state  <= ST_RDATA;
        end
        ST_RDATA: begin
          if (cnt == '0) begin
            oe_q  <= 1'b0;
            out_q <= 1'b0;
            state <= ST_TA2;
          end else begin
            out_q  <= data_q[DATA_W-1];
            data_q <= {data_q[DATA_W-2:0], 1'b0};
            cnt    <= cnt - 1'b1;
          end
        end
        ST_TA2:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: no drive while a write frame is in progress
  a_r8_no_drive_write: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WDATA || state == ST_STOP || (state == ST_ADDR && !rw_q)) |-> !oe_q);

  // R6: the drive always follows one undriven turnaround slot
  a_r6_turnaround_lead: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> $past(state == ST_TA1));

  // R7: after release the line stays undriven and the port returns to idle
  a_r7_turnaround_trail: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_q) |=> (!oe_q && state == ST_IDLE));

  // R5: a commit only ever follows the last data bit
  a_r5_commit_after_data: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(state == ST_WDATA));
endmodule

// File: rtl/srp_serial_port.sv
`timescale 1ns/1ps
module srp_serial_port #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 16,
  parameter int PM_ADDR  = 6,
  parameter logic [7:0] PM_RESET = 8'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sd_in,
  output logic              sd_out,
  output logic              sd_oe,
  output logic [DATA_W-1:0] pm_mode
);
  logic              rd_en, wr_en;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;

  srp_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .line_in (sd_in),
    .rd_data (rd_data),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .drv_oe  (sd_oe),
    .drv_bit (sd_out)
  );

  srp_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .PM_ADDR(PM_ADDR), .PM_RESET(PM_RESET)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pm_q    (pm_mode)
  );
endmodule

// File: tb/srp_serial_port_tb.sv
`timescale 1ns/1ps
module srp_serial_port_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mac_oe = 1'b0, mac_bit = 1'b0;
  logic sd_out, sd_oe;
  logic [7:0] pm_mode;
  logic line;
  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got;
  int nbits = 0;

  always #2 clk = ~clk;

  assign line = sd_oe ? sd_out : (mac_oe & mac_bit);

  srp_serial_port u_dut (
    .clk(clk), .rst(rst), .sd_in(line),
    .sd_out(sd_out), .sd_oe(sd_oe), .pm_mode(pm_mode)
  );

  function automatic void chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk);
    mac_oe  = 1'b1;
    mac_bit = b;
  endtask

  task automatic send_addr(input logic [7:0] a);
    for (int i = 7; i >= 0; i--) send_bit(a[i]);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic stopb);
    send_bit(1'b1);
    send_bit(1'b0);
    send_addr(a);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    send_bit(stopb);
    @(negedge clk);
    mac_oe = 1'b0; mac_bit = 1'b0;
  endtask

  // push the expected byte; the monitor checks the returned bits
  task automatic rd(input logic [7:0] a, input logic [7:0] expv);
    exp_q.push_back(expv);
    send_bit(1'b1);
    send_bit(1'b1);
    send_addr(a);
    @(negedge clk);
    mac_oe = 1'b0; mac_bit = 1'b0;
    chk(!sd_oe, "R6 turnaround before data", 32'(sd_oe), 0);
    repeat (8) @(negedge clk);
    @(negedge clk);
    chk(!sd_oe, "R7 release after data", 32'(sd_oe), 0);
  endtask

  // monitor: collect driven bits MSB first and compare with the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (sd_oe && mac_oe) chk(1'b0, "R8 bus contention", 1, 0);
      if (sd_oe) begin
        got = {got[6:0], sd_out};
        nbits++;
        if (nbits == 8) begin
          nbits = 0;
          if (exp_q.size() == 0) chk(1'b0, "R6 unexpected read data", 32'(got), 0);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(got == e, "R6/R3 read data", 32'(got), 32'(e));
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(!sd_oe, "R1 oe in reset", 32'(sd_oe), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!sd_oe, "R1 oe after reset", 32'(sd_oe), 0);
    chk(pm_mode == 8'h02, "R1 pm reset code", 32'(pm_mode), 32'h02);

    // R2: idle low line, no activity
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sd_oe) chk(1'b0, "R2 drive while idle", 1, 0);
    end
    chk(!sd_oe, "R2 idle", 32'(sd_oe), 0);

    // R3 R4: write then read back, asymmetric patterns
    wr(8'h03, 8'hA5, 1'b0);
    rd(8'h03, 8'hA5);
    wr(8'h0F, 8'h3C, 1'b0);
    wr(8'h00, 8'h81, 1'b0);
    rd(8'h0F, 8'h3C);
    rd(8'h00, 8'h81);

    // R10: power-mode write to READY
    wr(8'h06, 8'h00, 1'b0);
    chk(pm_mode == 8'h00, "R10 pm READY", 32'(pm_mode), 0);
    rd(8'h06, 8'h00);

    // R5: stop position carries 1, write discarded
    wr(8'h06, 8'h01, 1'b1);
    chk(pm_mode == 8'h00, "R5 pm unchanged", 32'(pm_mode), 0);
    wr(8'h03, 8'h5A, 1'b1);
    rd(8'h03, 8'hA5);

    // R9: out-of-range addresses
    wr(8'h16, 8'h55, 1'b0);
    chk(pm_mode == 8'h00, "R9 no alias onto pm", 32'(pm_mode), 0);
    wr(8'h13, 8'h77, 1'b0);
    rd(8'h03, 8'hA5);
    rd(8'h16, 8'h00);
    rd(8'h10, 8'h00);
    rd(8'hFF, 8'h00);

    // R7: back-to-back reads at the tightest spacing
    rd(8'h0F, 8'h3C);
    rd(8'h00, 8'h81);

    // R10 / R4: another power-mode value
    wr(8'h06, 8'h03, 1'b0);
    chk(pm_mode == 8'h03, "R10 pm write", 32'(pm_mode), 32'h03);
    rd(8'h06, 8'h03);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R6 pending reads", 32'(exp_q.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule